// File: doc/BRIEF.md
# Wait-State Access Latency Calculator

This block turns the timing description of one external memory region into the number of bus clock cycles that byte, halfword and word accesses to that region take. It reads two configuration words: a per-region delay word and a common delay word shared by all regions. It returns three cycle counts. A bus controller keeps one copy per region and reads the counts when it schedules an access.

The region word chooses which of the shared delay terms apply, and it supplies the region's own access time and data bus width. From these, the block forms a first-access count and a sequential-access count. It then applies a lower bound to each and builds the multi-beat totals from the bus width. The block does not decode addresses and does not stall the bus. It only reports the latencies.

Results are registered. A request with `in_valid` high produces its three counts one cycle later, flagged by `out_valid`. The counts hold their value until the next request.

Top module: `wsc_latency_calc`

## Requirements
- R1: When region bit 8 is set, the value (common bits [3:0] minus one) is added to both the first and sequential counts. A zero there contributes minus one, and the outputs never wrap.
- R2: When region bit 10 is set, common bits [11:8] are added to both the first and sequential counts.
- R3: When region bit 11 is set, common bits [15:12] set a floor term. If the bit is clear, the floor term is zero. The first count is raised to at least floor+6 and the sequential count to at least floor+2, so `lat_byte` is never below 6.
- R4: After the optional terms of R1 and R2 are summed, the first count gets one extra cycle only if that sum is below 6. A sum of 5 gets the cycle and a sum of 6 does not.
- R5: Region bits [7:4], the access time, plus 2 are added to both counts after the R4 adjustment and before the R3 floor.
- R6: `lat_byte` equals the first count. When region bit 12 is 1 (16-bit bus), `lat_half` equals first and `lat_word` equals first+seq. When bit 12 is 0 (8-bit bus), `lat_half` equals first+seq and `lat_word` equals first+3×seq.
- R7: The outputs do not depend on region bits [3:0], bit 9, bits [31:13], common bits [7:4] or common bits [31:16].
- R8: `out_valid` rises exactly one cycle after `in_valid`. The counts hold while `in_valid` is low. Reset clears `out_valid` and all counts to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request to evaluate the two configuration words |
| region_cfg | input | CFG_W | Per-region delay word |
| common_cfg | input | CFG_W | Shared common delay word |
| out_valid | output | 1 | Counts below are fresh this cycle |
| lat_byte | output | OUT_W | Byte access latency in cycles |
| lat_half | output | OUT_W | Halfword access latency in cycles |
| lat_word | output | OUT_W | Word access latency in cycles |

## Verification
The bench builds the block with its default parameters: 32-bit configuration words, 4-bit delay fields, 8-bit outputs and the registered output variant. With 4-bit fields, every field value can be reached. This covers the common-0 value of zero that drives the sum negative, and the largest 8-bit-bus word total of 184, which sits just under the 8-bit output limit. The registered variant also exposes the one-cycle result timing and the hold behaviour between requests.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   // Region delay word positions (decoded by neighbouring bus logic too)
   localparam int ACC_LSB     = 4;
   localparam int USE_C0_BIT  = 8;
   localparam int USE_C2_BIT  = 10;
   localparam int USE_C3_BIT  = 11;
   localparam int BUS16_BIT   = 12;
   // Common delay word slots
   localparam int COM_SLOTS   = 4;
   localparam int C0_SLOT     = 0;
   localparam int C2_SLOT     = 2;
   localparam int C3_SLOT     = 3;
   // Arithmetic constants
   localparam int BUMP_LIMIT  = 6;
   localparam int FIRST_FLOOR = 6;
   localparam int SEQ_FLOOR   = 2;
   localparam int ACC_BIAS    = 2;

   typedef enum logic {
      BUS_8BIT  = 1'b0,
      BUS_16BIT = 1'b1
   } bus_width_e;
endpackage

// File: rtl/wsc_field_decode.sv
module wsc_field_decode
   import wsc_pkg::*;
#(
   parameter int CFG_W = 32,
   parameter int COM_W = 4,
   parameter int ACC_W = 4
) (
   input  logic [CFG_W-1:0] region_cfg,
   input  logic [CFG_W-1:0] common_cfg,
   output logic [ACC_W-1:0] acc_time,
   output logic             use_c0,
   output logic             use_c2,
   output logic             use_c3,
   output bus_width_e       bus_w,
   output logic [COM_W-1:0] c0_val,
   output logic [COM_W-1:0] c2_val,
   output logic [COM_W-1:0] c3_val
);
   logic cfg_unused;

   assign acc_time = region_cfg[ACC_LSB +: ACC_W];
   assign use_c0   = region_cfg[USE_C0_BIT];
   assign use_c2   = region_cfg[USE_C2_BIT];
   assign use_c3   = region_cfg[USE_C3_BIT];
   assign bus_w    = bus_width_e'(region_cfg[BUS16_BIT]);

   assign c0_val = common_cfg[C0_SLOT*COM_W +: COM_W];
   assign c2_val = common_cfg[C2_SLOT*COM_W +: COM_W];
   assign c3_val = common_cfg[C3_SLOT*COM_W +: COM_W];

   // Fields that carry no timing meaning here
   assign cfg_unused = ^{region_cfg, common_cfg};
endmodule

// File: rtl/wsc_base_calc.sv
module wsc_base_calc
   import wsc_pkg::*;
#(
   parameter int COM_W = 4,
   parameter int ACC_W = 4,
   parameter int INT_W = 10,
   parameter int OUT_W = 8
) (
   input  logic [ACC_W-1:0] acc_time,
   input  logic             use_c0,
   input  logic             use_c2,
   input  logic             use_c3,
   input  logic [COM_W-1:0] c0_val,
   input  logic [COM_W-1:0] c2_val,
   input  logic [COM_W-1:0] c3_val,
   output logic [OUT_W-1:0] first_cyc,
   output logic [OUT_W-1:0] seq_cyc
);
   localparam logic signed [INT_W-1:0] ONE_S   = INT_W'(1);
   localparam logic signed [INT_W-1:0] LIMIT_S = INT_W'(BUMP_LIMIT);
   localparam logic signed [INT_W-1:0] BIAS_S  = INT_W'(ACC_BIAS);
   localparam logic signed [INT_W-1:0] FFLR_S  = INT_W'(FIRST_FLOOR);
   localparam logic signed [INT_W-1:0] SFLR_S  = INT_W'(SEQ_FLOOR);

   function automatic logic signed [INT_W-1:0] widen_c(input logic [COM_W-1:0] v);
      return $signed(INT_W'(v));
   endfunction

   function automatic logic signed [INT_W-1:0] widen_a(input logic [ACC_W-1:0] v);
      return $signed(INT_W'(v));
   endfunction

   logic signed [INT_W-1:0] opt_sum;
   logic signed [INT_W-1:0] floor_term;
   logic signed [INT_W-1:0] bumped;
   logic signed [INT_W-1:0] first_raw;
   logic signed [INT_W-1:0] seq_raw;
   logic signed [INT_W-1:0] first_min;
   logic signed [INT_W-1:0] seq_min;
   logic signed [INT_W-1:0] first_s;
   logic signed [INT_W-1:0] seq_s;

   always_comb begin
      opt_sum = '0;
      if (use_c0) opt_sum = opt_sum + widen_c(c0_val) - ONE_S;
      if (use_c2) opt_sum = opt_sum + widen_c(c2_val);
      floor_term = use_c3 ? widen_c(c3_val) : '0;
   end

   always_comb begin
      bumped    = (opt_sum < LIMIT_S) ? (opt_sum + ONE_S) : opt_sum;
      first_raw = bumped  + widen_a(acc_time) + BIAS_S;
      seq_raw   = opt_sum + widen_a(acc_time) + BIAS_S;
      first_min = floor_term + FFLR_S;
      seq_min   = floor_term + SFLR_S;
      first_s   = (first_raw < first_min) ? first_min : first_raw;
      seq_s     = (seq_raw   < seq_min)   ? seq_min   : seq_raw;
   end

   // Both results are at least 2 after clamping, so the unsigned view is exact
   assign first_cyc = OUT_W'($unsigned(first_s));
   assign seq_cyc   = OUT_W'($unsigned(seq_s));
endmodule

// File: rtl/wsc_beat_totals.sv
module wsc_beat_totals
   import wsc_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic [OUT_W-1:0] first_cyc,
   input  logic [OUT_W-1:0] seq_cyc,
   input  bus_width_e       bus_w,
   output logic [OUT_W-1:0] tot_byte,
   output logic [OUT_W-1:0] tot_half,
   output logic [OUT_W-1:0] tot_word
);
   logic [OUT_W-1:0] two_beat;
   logic [OUT_W-1:0] four_beat;

   assign two_beat  = first_cyc + seq_cyc;
   // first + 3*seq as a shift-add
   assign four_beat = two_beat + {seq_cyc[OUT_W-2:0], 1'b0};

   always_comb begin
      tot_byte = first_cyc;
      unique case (bus_w)
         BUS_16BIT: begin
            tot_half = first_cyc;
            tot_word = two_beat;
         end
         default: begin
            tot_half = two_beat;
            tot_word = four_beat;
         end
      endcase
   end
endmodule

// File: rtl/wsc_latency_calc.sv
module wsc_latency_calc
   import wsc_pkg::*;
#(
   parameter int CFG_W    = 32,
   parameter int COM_W    = 4,
   parameter int ACC_W    = 4,
   parameter int OUT_W    = 8,
   parameter bit PIPE_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [CFG_W-1:0] region_cfg,
   input  logic [CFG_W-1:0] common_cfg,
   output logic             out_valid,
   output logic [OUT_W-1:0] lat_byte,
   output logic [OUT_W-1:0] lat_half,
   output logic [OUT_W-1:0] lat_word
);
   localparam int COM_MAX   = (1 << COM_W) - 1;
   localparam int ACC_MAX   = (1 << ACC_W) - 1;
   localparam int SUM_MAX   = (COM_MAX - 1) + COM_MAX + ACC_MAX + ACC_BIAS + 1;
   localparam int FLR_MAX   = COM_MAX + FIRST_FLOOR;
   localparam int FIRST_MAX = (SUM_MAX > FLR_MAX) ? SUM_MAX : FLR_MAX;
   localparam int NEED_W    = $clog2(4 * FIRST_MAX + 1);
   localparam int INT_W     = NEED_W + 2;

   if (OUT_W < NEED_W) begin : g_chk_out_w
      $error("OUT_W too narrow for the largest word latency");
   end
   if (CFG_W < COM_SLOTS * COM_W || CFG_W <= BUS16_BIT) begin : g_chk_cfg_w
      $error("CFG_W cannot hold the configuration fields");
   end
   if (ACC_LSB + ACC_W > USE_C0_BIT) begin : g_chk_acc_w
      $error("ACC_W overlaps the flag bits");
   end

   logic [ACC_W-1:0] acc_time;
   logic             use_c0, use_c2, use_c3;
   bus_width_e       bus_w;
   logic [COM_W-1:0] c0_val, c2_val, c3_val;
   logic [OUT_W-1:0] first_cyc, seq_cyc;
   logic [OUT_W-1:0] nxt_byte, nxt_half, nxt_word;

   wsc_field_decode #(.CFG_W(CFG_W), .COM_W(COM_W), .ACC_W(ACC_W)) u_decode (
      .region_cfg (region_cfg),
      .common_cfg (common_cfg),
      .acc_time   (acc_time),
      .use_c0     (use_c0),
      .use_c2     (use_c2),
      .use_c3     (use_c3),
      .bus_w      (bus_w),
      .c0_val     (c0_val),
      .c2_val     (c2_val),
      .c3_val     (c3_val)
   );

   wsc_base_calc #(.COM_W(COM_W), .ACC_W(ACC_W), .INT_W(INT_W), .OUT_W(OUT_W)) u_base (
      .acc_time  (acc_time),
      .use_c0    (use_c0),
      .use_c2    (use_c2),
      .use_c3    (use_c3),
      .c0_val    (c0_val),
      .c2_val    (c2_val),
      .c3_val    (c3_val),
      .first_cyc (first_cyc),
      .seq_cyc   (seq_cyc)
   );

   wsc_beat_totals #(.OUT_W(OUT_W)) u_totals (
      .first_cyc (first_cyc),
      .seq_cyc   (seq_cyc),
      .bus_w     (bus_w),
      .tot_byte  (nxt_byte),
      .tot_half  (nxt_half),
      .tot_word  (nxt_word)
   );

   if (PIPE_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            lat_byte  <= '0;
            lat_half  <= '0;
            lat_word  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               lat_byte <= nxt_byte;
               lat_half <= nxt_half;
               lat_word <= nxt_word;
            end
         end
      end
   end else begin : g_comb_out
      logic clk_unused;
      assign clk_unused = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign lat_byte   = nxt_byte;
      assign lat_half   = nxt_half;
      assign lat_word   = nxt_word;
   end
endmodule

// File: rtl/wsc_latency_chk.sv
module wsc_latency_chk #(
   parameter int CFG_W    = 32,
   parameter int COM_W    = 4,
   parameter int OUT_W    = 8,
   parameter bit PIPE_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [CFG_W-1:0] region_cfg,
   input logic [CFG_W-1:0] common_cfg,
   input logic             out_valid,
   input logic [OUT_W-1:0] lat_byte,
   input logic [OUT_W-1:0] lat_half,
   input logic [OUT_W-1:0] lat_word
);
   logic chk_unused;
   assign chk_unused = ^{region_cfg, common_cfg};

   AST_BYTE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> lat_byte >= OUT_W'(6)); // R3

   AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lat_half >= lat_byte) && (lat_word > lat_half)); // R6

   if (PIPE_OUT) begin : g_pipe_props
      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R8

      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R8

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(lat_byte) && $stable(lat_half) && $stable(lat_word)); // R8

      AST_BUS16_HALF: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && region_cfg[12] |=> lat_half == lat_byte); // R6

      AST_FLOOR_C3: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && region_cfg[11] |=>
            lat_byte >= OUT_W'($past(common_cfg[3*COM_W +: COM_W])) + OUT_W'(6)); // R3
   end else begin : g_comb_props
      AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid); // R8
   end
endmodule

bind wsc_latency_calc wsc_latency_chk #(
   .CFG_W(CFG_W), .COM_W(COM_W), .OUT_W(OUT_W), .PIPE_OUT(PIPE_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .region_cfg (region_cfg),
   .common_cfg (common_cfg),
   .out_valid  (out_valid),
   .lat_byte   (lat_byte),
   .lat_half   (lat_half),
   .lat_word   (lat_word)
);

// File: tb/wsc_latency_calc_test.sv
module wsc_latency_calc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] region_cfg = '0;
   logic [31:0] common_cfg = '0;
   logic        out_valid;
   logic [7:0]  lat_byte, lat_half, lat_word;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int    qb[$], qh[$], qw[$];
   string qt[$];
   int    last_b = 0, last_h = 0, last_w = 0;

   always #10 clk = ~clk;

   wsc_latency_calc uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .region_cfg(region_cfg), .common_cfg(common_cfg),
      .out_valid(out_valid), .lat_byte(lat_byte),
      .lat_half(lat_half), .lat_word(lat_word)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference computation written from the requirements
   function automatic void model(input logic [31:0] r, input logic [31:0] c,
                                 output int b, output int h, output int w);
      int f, s, m;
      f = 0; s = 0; m = 0;
      if (r[8])  begin f += int'(c[3:0]) - 1; s += int'(c[3:0]) - 1; end   // R1
      if (r[10]) begin f += int'(c[11:8]);    s += int'(c[11:8]);    end   // R2
      if (r[11]) m = int'(c[15:12]);                                       // R3
      if (f < 6) f++;                                                      // R4
      f += int'(r[7:4]) + 2;                                               // R5
      s += int'(r[7:4]) + 2;
      if (f < m + 6) f = m + 6;
      if (s < m + 2) s = m + 2;
      b = f;                                                               // R6
      h = r[12] ? f : f + s;
      w = r[12] ? f + s : f + 3 * s;
   endfunction

   task automatic drive(input logic [31:0] r, input logic [31:0] c, input string tag);
      int b, h, w;
      @(negedge clk);
      in_valid   = 1'b1;
      region_cfg = r;
      common_cfg = c;
      model(r, c, b, h, w);
      qb.push_back(b); qh.push_back(h); qw.push_back(w); qt.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: compares each fresh result with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (qb.size() == 0) begin
            check("R8 unexpected out_valid", 1, 0);
         end else begin
            string t;
            t = qt.pop_front();
            last_b = qb.pop_front();
            last_h = qh.pop_front();
            last_w = qw.pop_front();
            check({t, " byte"}, int'(lat_byte), last_b);
            check({t, " half"}, int'(lat_half), last_h);
            check({t, " word"}, int'(lat_word), last_w);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset out_valid", int'(out_valid), 0);
      check("R8 reset byte", int'(lat_byte), 0);
      check("R8 reset word", int'(lat_word), 0);
      rst_n = 1'b1;
      idle(2);

      // Typical settings, 8-bit bus
      drive(32'h0013_243F, 32'h0003_1125, "R6 typical 8-bit");
      drive(32'h0000_1030, 32'h0000_0000, "R6 16-bit bus");
      drive(32'h0000_0130, 32'h0000_0009, "R1 com0 term");
      drive(32'h0000_0100, 32'h0000_0000, "R1 com0 zero no wrap");
      drive(32'h0000_0400, 32'h0000_0500, "R2 com2=5 bump");
      drive(32'h0000_0400, 32'h0000_0600, "R4 sum 6 no bump");
      drive(32'h0000_0500, 32'h0000_0006, "R4 sum 5 via com0");
      drive(32'h0000_0800, 32'h0000_F000, "R3 floor com3=15");
      drive(32'h0000_1800, 32'h0000_9000, "R3 floor 16-bit");
      drive(32'h0000_00F0, 32'h0000_0000, "R5 access max");
      drive(32'h0000_0F00, 32'h0000_FFFF, "R2 all terms max");
      drive(32'h0000_0DF0, 32'h0000_FFFF, "R6 largest word");
      idle(3);
      check("R8 hold byte", int'(lat_byte), last_b);
      check("R8 hold word", int'(lat_word), last_w);
      check("R8 idle out_valid", int'(out_valid), 0);

      // Ignored fields set everywhere else
      drive(32'hFFFF_E22F, 32'hFFFF_00F0, "R7 ignored bits");
      drive(32'h0000_0000, 32'h0000_0000, "R7 ignored bits clear");
      idle(1);

      for (int i = 0; i < 200; i++) begin
         drive($urandom, $urandom, "R6 random");
         if (i % 7 == 3) idle(i % 3 + 1);
      end
      idle(3);
      check("R8 scoreboard drained", qb.size(), 0);
      check("R8 hold half", int'(lat_half), last_h);
      finish_run();
   end
endmodule